// File: doc/BRIEF.md
# Flag Threshold Loader

This block holds the two threshold values that a clocked queue's partial-fill flags compare against: one measured up from the empty boundary and one measured down from the full boundary. Both values are loaded from the write-side data bus and read back through the read-side data output. A single active-low load strobe selects this path. While the strobe is low, the queue's own write and read strobes are held off.

Neither access carries an address. The write side and the read side each keep a one-bit selector, and that selector alternates between the two thresholds on every qualified access: empty threshold first, then full threshold, then empty again. Raising the load strobe ends the session and points both selectors back at the empty threshold. Both thresholds are driven out continuously to the flag comparison logic.

The read-side output register is shared. A normal queue read loads it with the storage word. A load-mode read loads it with the selected threshold, zero-extended to the output width. The two thresholds live in the write-clock domain and are expected to stay still while they are being read back.

Top module: `ofs_loader`

## Requirements
- R1: While the asynchronous reset rst_ni is low, both thresholds are 127, q_o is 0 and both selectors point at the empty threshold.
- R2: With load_ni low and wen_ni low, the first wclk_i rising edge of a session stores wdata_i into the empty threshold (empty_ofs_o) and leaves the full threshold unchanged.
- R3: Successive qualified write edges in one session alternate targets: the 2nd edge writes the full threshold (full_ofs_o), the 3rd writes the empty threshold, and so on.
- R4: With load_ni low and wen_ni high, a wclk_i edge changes neither threshold and does not advance the write selector.
- R5: With load_ni low and ren_ni low, successive rclk_i rising edges load q_o with the empty threshold, then the full threshold, then the empty threshold again, with bits above the threshold width set to 0.
- R6: While load_ni is low, fifo_we_o and fifo_re_o are 0 whatever wen_ni and ren_ni are.
- R7: While load_ni is high, fifo_we_o equals the inverse of wen_ni and fifo_re_o equals the inverse of ren_ni. An rclk_i edge with fifo_re_o high loads q_o with fifo_q_i, an edge without it holds q_o, and writes never change the thresholds.
- R8: Any clock edge with load_ni high points that clock's selector back at the empty threshold, so the next session starts with the empty threshold.
- R9: The write and read selectors advance independently. A load-mode write and a load-mode read on the same edge each act on their own selector, and the read returns the value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Threshold access strobe, active low |
| wen_ni | input | 1 | Write enable, active low |
| ren_ni | input | 1 | Read enable, active low |
| wdata_i | input | OFS_W (16) | Threshold value on the write side |
| fifo_q_i | input | DATA_W (18) | Word presented by queue storage |
| fifo_we_o | output | 1 | Queue write strobe, active high |
| fifo_re_o | output | 1 | Queue read strobe, active high |
| q_o | output | DATA_W (18) | Registered read-side data output |
| empty_ofs_o | output | OFS_W (16) | Empty-side threshold for flag logic |
| full_ofs_o | output | OFS_W (16) | Full-side threshold for flag logic |

## Verification
A load-mode write and a load-mode read can fall on the same clock edge, and their selectors can then point at the same threshold or at different ones. The bench ties both clocks to one source and drives load_ni, wen_ni and ren_ni low together after an odd number of writes and an odd number of reads, so both selectors aim at the full threshold. It then checks that q_o shows the full threshold as it was before the edge and that full_ofs_o shows the new value after the edge. A later single read after load_ni has been high confirms that the read selector was rewound separately from the write selector.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  function automatic ofs_sel_e sel_next(input ofs_sel_e cur);
    return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction
endpackage

// File: rtl/ofs_strobe_gate.sv
module ofs_strobe_gate (
  input  logic load_ni,
  input  logic wen_ni,
  input  logic ren_ni,
  output logic fifo_we_o,
  output logic fifo_re_o,
  output logic ofs_wr_o,
  output logic ofs_rd_o
);
  // load low steals both strobes from the queue
  always_comb begin
    fifo_we_o = load_ni  & ~wen_ni;
    fifo_re_o = load_ni  & ~ren_ni;
    ofs_wr_o  = ~load_ni & ~wen_ni;
    ofs_rd_o  = ~load_ni & ~ren_ni;
  end

  always_comb begin
    assert_exclusive_R6: assert (!(fifo_we_o && ofs_wr_o) && !(fifo_re_o && ofs_rd_o));
  end
endmodule

// File: rtl/ofs_wr_bank.sv
module ofs_wr_bank
  import ofs_loader_pkg::*;
#(
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned DEF_OFS = 127
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             wr_i,
  input  logic [OFS_W-1:0] wdata_i,
  output logic [OFS_W-1:0] empty_ofs_o,
  output logic [OFS_W-1:0] full_ofs_o
);
  localparam logic [OFS_W-1:0] DefVal = OFS_W'(DEF_OFS);

  ofs_sel_e         sel_q;
  logic [OFS_W-1:0] empty_q, full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= SEL_EMPTY;
    else if (load_ni)  sel_q <= SEL_EMPTY;
    else if (wr_i)     sel_q <= sel_next(sel_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= DefVal;
      full_q  <= DefVal;
    end else if (wr_i) begin
      if (sel_q == SEL_EMPTY) empty_q <= wdata_i;
      else                    full_q  <= wdata_i;
    end
  end

  assign empty_ofs_o = empty_q;
  assign full_ofs_o  = full_q;

  assert_first_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(load_ni) && !load_ni && wr_i) |=> (empty_q == $past(wdata_i)) && $stable(full_q));
  assert_alternate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && wr_i) |=> (sel_q != $past(sel_q)));
  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(empty_q) && $stable(full_q)));
  assert_rewind_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni |=> (sel_q == SEL_EMPTY));
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import ofs_loader_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned OFS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic              rd_i,
  input  logic              fifo_re_i,
  input  logic [DATA_W-1:0] fifo_q_i,
  input  logic [OFS_W-1:0]  empty_ofs_i,
  input  logic [OFS_W-1:0]  full_ofs_i,
  output logic [DATA_W-1:0] q_o
);
  localparam int unsigned PadW = DATA_W - OFS_W;

  ofs_sel_e          sel_q;
  logic [OFS_W-1:0]  pick;
  logic [DATA_W-1:0] pick_ext;
  logic [DATA_W-1:0] q_q;

  assign pick = (sel_q == SEL_EMPTY) ? empty_ofs_i : full_ofs_i;

  generate
    if (PadW > 0) begin : g_pad
      assign pick_ext = {{PadW{1'b0}}, pick};
    end else begin : g_nopad
      assign pick_ext = pick;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= SEL_EMPTY;
    else if (load_ni)  sel_q <= SEL_EMPTY;
    else if (rd_i)     sel_q <= sel_next(sel_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_q <= '0;
    else if (rd_i)       q_q <= pick_ext;
    else if (fifo_re_i)  q_q <= fifo_q_i;
  end

  assign q_o = q_q;

  assert_rd_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && rd_i) |=> (sel_q != $past(sel_q)));
  assert_q_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !fifo_re_i) |=> $stable(q_q));
  assert_rd_rewind_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni |=> (sel_q == SEL_EMPTY));
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader #(
  parameter int unsigned DATA_W  = 18,
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned DEF_OFS = 127
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic              wen_ni,
  input  logic              ren_ni,
  input  logic [OFS_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0] fifo_q_i,
  output logic              fifo_we_o,
  output logic              fifo_re_o,
  output logic [DATA_W-1:0] q_o,
  output logic [OFS_W-1:0]  empty_ofs_o,
  output logic [OFS_W-1:0]  full_ofs_o
);
  logic ofs_wr, ofs_rd;

  ofs_strobe_gate u_gate (
    .load_ni   (load_ni),
    .wen_ni    (wen_ni),
    .ren_ni    (ren_ni),
    .fifo_we_o (fifo_we_o),
    .fifo_re_o (fifo_re_o),
    .ofs_wr_o  (ofs_wr),
    .ofs_rd_o  (ofs_rd)
  );

  ofs_wr_bank #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_wr (
    .clk_i       (wclk_i),
    .rst_ni      (rst_ni),
    .load_ni     (load_ni),
    .wr_i        (ofs_wr),
    .wdata_i     (wdata_i),
    .empty_ofs_o (empty_ofs_o),
    .full_ofs_o  (full_ofs_o)
  );

  ofs_rd_port #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rd (
    .clk_i       (rclk_i),
    .rst_ni      (rst_ni),
    .load_ni     (load_ni),
    .rd_i        (ofs_rd),
    .fifo_re_i   (fifo_re_o),
    .fifo_q_i    (fifo_q_i),
    .empty_ofs_i (empty_ofs_o),
    .full_ofs_i  (full_ofs_o),
    .q_o         (q_o)
  );

  assert_no_queue_wr_R6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !load_ni |-> !fifo_we_o);
  assert_no_queue_rd_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !load_ni |-> !fifo_re_o);
  assert_thr_frozen_R7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    load_ni |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));
endmodule

// File: tb/ofs_loader_tb_top.sv
module ofs_loader_tb_top;
  localparam int unsigned DATA_W = 18;
  localparam int unsigned OFS_W  = 16;

  typedef struct packed {
    logic              ld_n;
    logic              wen_n;
    logic              ren_n;
    logic [OFS_W-1:0]  wd;
    logic [DATA_W-1:0] fq;
    logic              x_we;
    logic              x_re;
    logic [OFS_W-1:0]  x_e;
    logic [OFS_W-1:0]  x_f;
    logic [DATA_W-1:0] x_q;
    logic [7:0]        req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,16'h0011,18'h12345,1'b1,1'b1,16'd127, 16'd127, 18'h12345,8'd7}, // R7 normal pass
    '{1'b0,1'b0,1'b1,16'h0040,18'h00000,1'b0,1'b0,16'h0040,16'd127, 18'h12345,8'd2}, // R2 first -> empty
    '{1'b0,1'b1,1'b1,16'hFFFF,18'h00000,1'b0,1'b0,16'h0040,16'd127, 18'h12345,8'd4}, // R4 no-op
    '{1'b0,1'b0,1'b1,16'h0200,18'h00000,1'b0,1'b0,16'h0040,16'h0200,18'h12345,8'd3}, // R3 second -> full
    '{1'b0,1'b0,1'b1,16'h0033,18'h00000,1'b0,1'b0,16'h0033,16'h0200,18'h12345,8'd3}, // R3 third -> empty
    '{1'b1,1'b1,1'b1,16'h0000,18'h00000,1'b0,1'b0,16'h0033,16'h0200,18'h12345,8'd8}, // R8 session end
    '{1'b0,1'b0,1'b1,16'h0050,18'h00000,1'b0,1'b0,16'h0050,16'h0200,18'h12345,8'd8}, // R8 restart at empty
    '{1'b0,1'b1,1'b0,16'h0000,18'h00000,1'b0,1'b0,16'h0050,16'h0200,18'h00050,8'd5}, // R5 read empty
    '{1'b0,1'b1,1'b0,16'h0000,18'h00000,1'b0,1'b0,16'h0050,16'h0200,18'h00200,8'd5}, // R5 read full
    '{1'b0,1'b1,1'b0,16'h0000,18'h00000,1'b0,1'b0,16'h0050,16'h0200,18'h00050,8'd5}, // R5 wrap to empty
    '{1'b0,1'b0,1'b0,16'h0077,18'h00000,1'b0,1'b0,16'h0050,16'h0077,18'h00200,8'd9}, // R9 same-edge wr+rd
    '{1'b1,1'b0,1'b0,16'hABCD,18'h2F00F,1'b1,1'b1,16'h0050,16'h0077,18'h2F00F,8'd7}, // R7 queue read
    '{1'b0,1'b1,1'b0,16'h0000,18'h00000,1'b0,1'b0,16'h0050,16'h0077,18'h00050,8'd8}, // R8 read rewound
    '{1'b1,1'b1,1'b1,16'h0000,18'h11111,1'b0,1'b0,16'h0050,16'h0077,18'h00050,8'd7}  // R7 q holds
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ld_n, wen_n, ren_n;
  logic [OFS_W-1:0]  wd;
  logic [DATA_W-1:0] fq;
  logic              we, re;
  logic [DATA_W-1:0] q;
  logic [OFS_W-1:0]  e_ofs, f_ofs;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ofs_loader dut_i (
    .wclk_i      (clk),
    .rclk_i      (clk),
    .rst_ni      (rst_n),
    .load_ni     (ld_n),
    .wen_ni      (wen_n),
    .ren_ni      (ren_n),
    .wdata_i     (wd),
    .fifo_q_i    (fq),
    .fifo_we_o   (we),
    .fifo_re_o   (re),
    .q_o         (q),
    .empty_ofs_o (e_ofs),
    .full_ofs_o  (f_ofs)
  );

  task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1; wd = '0; fq = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("reset empty thr", 1, 32'(e_ofs), 32'd127);
    chk("reset full thr",  1, 32'(f_ofs), 32'd127);
    chk("reset q",         1, 32'(q),     32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      ld_n = VECS[i].ld_n; wen_n = VECS[i].wen_n; ren_n = VECS[i].ren_n;
      wd = VECS[i].wd; fq = VECS[i].fq;
      #1;
      // R6 / R7 strobe gating
      chk("fifo_we", int'(VECS[i].req), 32'(we), 32'(VECS[i].x_we));
      chk("fifo_re", int'(VECS[i].req), 32'(re), 32'(VECS[i].x_re));
      @(negedge clk);
      chk("empty thr", int'(VECS[i].req), 32'(e_ofs), 32'(VECS[i].x_e));
      chk("full thr",  int'(VECS[i].req), 32'(f_ofs), 32'(VECS[i].x_f));
      chk("q",         int'(VECS[i].req), 32'(q),     32'(VECS[i].x_q));
    end

    // R1 reset mid-session: write selector left at full, reset rewinds it
    ld_n = 1'b0; wen_n = 1'b0; ren_n = 1'b1; wd = 16'h0101;
    @(negedge clk);
    chk("pre-reset empty thr", 3, 32'(e_ofs), 32'h0101);
    rst_n = 1'b0; #1;
    chk("async reset empty thr", 1, 32'(e_ofs), 32'd127);
    chk("async reset full thr",  1, 32'(f_ofs), 32'd127);
    chk("async reset q",         1, 32'(q),     32'd0);
    @(negedge clk);
    rst_n = 1'b1; wd = 16'h0005;
    @(negedge clk);
    chk("post-reset first write hits empty", 1, 32'(e_ofs), 32'h0005);
    chk("post-reset full untouched",         1, 32'(f_ofs), 32'd127);
    // R6 all strobes blocked in load mode
    ren_n = 1'b0; #1;
    chk("we blocked", 6, 32'(we), 32'd0);
    chk("re blocked", 6, 32'(re), 32'd0);
    @(negedge clk);
    // R5 read-side selector was also rewound by reset
    chk("post-reset read gives empty", 5, 32'(q), 32'h0005);
    ld_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule